// File: doc/BRIEF.md
# Programmable Timing State Sequencer

This block plays back a short program of timing states. Software fills up to ten 16-bit entries. A start pulse then makes the sequencer walk through them from entry 0 upwards. While an entry is active, its control fields drive five outputs: an excitation enable, a capacitor-connect enable, a resistor/oscillator enable, a DAC enable and a 2-bit channel select. The entry stays active for a programmed number of clock periods. Those periods come from one of two sources. The fast system clock times the state directly. The slow auxiliary clock times it by counting its rising edges.

The whole block runs in the fast clock domain. The slow clock is treated as an asynchronous input. A two-stage synchronizer followed by an edge detector turns it into a one-cycle count enable. As a result, a slow-timed state that starts part way through a slow period can be shorter than one full slow period. The run ends after the duration of the first entry whose stop bit is set, or after entry 9. When the run ends, all outputs return low.

Top module: `tseq_top`

## Requirements
- R1: After reset the sequencer is idle: `busy` is low and every control output is low.
- R2: A `start` sampled high on a rising clock edge while idle sets `busy` from the next cycle and makes entry 0 the active entry.
- R3: When an entry's duration expires and the run does not end, the next entry is the one with the next higher index.
- R4: While an entry is active, its fields drive the outputs. Bits [7:6] drive `chan`. Bit 8 drives `exc_en`, bit 9 drives `cap_en`, bit 10 drives `osc_en` and bit 11 drives `dac_en`. Bits [14:12] have no effect.
- R5: An entry with bit 5 clear and repeat field bits [4:0] equal to n stays active for exactly n+1 fast clock cycles.
- R6: An entry with bit 5 set stays active until the (n+1)-th counted slow-clock rising edge. A slow rising edge is counted on the third fast clock edge after the slow input rises (two synchronizer stages, then edge detection). The first counted edge may arrive less than one slow period into the state.
- R7: When an entry with bit 15 set finishes its duration, the run ends. From the next cycle, `busy` and all control outputs are low.
- R8: When entry 9 finishes its duration, the run ends even if its bit 15 is clear.
- R9: A `start` pulse while `busy` is high has no effect on the running sequence.
- R10: A write (`wr_en` high) updates entry `wr_addr` only when the sequencer is idle and `wr_addr` is below 10. Writes while busy, and writes to addresses 10 to 15, change no entry.
- R11: While idle, all control outputs are held low whatever the entry contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sequencer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_clk | input | 1 | Slow auxiliary clock, asynchronous to clk |
| start | input | 1 | Run start request, sampled on clk |
| wr_en | input | 1 | Entry write strobe |
| wr_addr | input | 4 | Entry index to write |
| wr_data | input | 16 | Entry contents |
| busy | output | 1 | High while a run is in progress |
| exc_en | output | 1 | Excitation enable of the active entry |
| cap_en | output | 1 | Capacitor-connect enable of the active entry |
| osc_en | output | 1 | Resistor/oscillator enable of the active entry |
| dac_en | output | 1 | DAC enable of the active entry |
| chan | output | 2 | Channel select of the active entry |

## Verification
The bench targets the repeat boundary: a repeat of 0 must give a one-cycle state, and an off-by-one counter would stretch or clip every state. Runs alternate fast-timed and slow-timed entries while the slow input toggles at a period unrelated to the state lengths. A synchronizer with the wrong depth, or an edge detector that counts levels instead of edges, would shift or shorten the slow states. A table with no stop bits checks that the run ends after entry 9 and does not wrap or read past the table. Start pulses and writes are issued in the middle of a run, and writes are also sent to unused addresses. A design that restarted, or that let a write through, would show different outputs on the following run.

// File: rtl/tseq_pkg.sv
// Package: shared sizes and entry field positions for the timing sequencer.
// Assumes a 16-bit entry word; positions are fixed because software encodes them.
package tseq_pkg;
    localparam int ENTRY_W   = 16;
    localparam int REP_W     = 5;
    localparam int REP_LSB   = 0;
    localparam int SEL_BIT   = 5;
    localparam int CHAN_LSB  = 6;
    localparam int EXC_BIT   = 8;
    localparam int CAP_BIT   = 9;
    localparam int OSC_BIT   = 10;
    localparam int DAC_BIT   = 11;
    localparam int STOP_BIT  = 15;

    // Output group driven by the active entry
    typedef struct packed {
        logic       exc;
        logic       cap;
        logic       osc;
        logic       dac;
        logic [1:0] chan;
    } drive_t;
endpackage

// File: rtl/tseq_entry_bank.sv
// Module: tseq_entry_bank
// Holds the programmed state entries. A write lands only when lock is low
// and the address names an existing entry. Assumes the writer holds wr_addr
// and wr_data stable for the strobed cycle.
module tseq_entry_bank #(
    parameter int NUM   = 10,
    parameter int DW    = 16,
    parameter int AW    = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [AW-1:0]            wr_addr,
    input  logic [DW-1:0]            wr_data,
    input  logic                     lock,
    output logic [NUM-1:0][DW-1:0]   tbl
);
    for (genvar g = 0; g < NUM; g++) begin : g_entry
        // Per-entry storage with idle-only write
        always_ff @(posedge clk) begin
            if (!rst_n)
                tbl[g] <= '0;
            else if (wr_en && !lock && (wr_addr == AW'(g)))
                tbl[g] <= wr_data;
        end
    end
endmodule

// File: rtl/tseq_edge_sync.sv
// Module: tseq_edge_sync
// Brings an asynchronous slow clock into the fast domain through STAGES
// flops and flags each rising edge for one fast cycle. Assumes the slow
// clock stays high and low for at least two fast cycles each.
module tseq_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    localparam int LEN = STAGES + 1;

    logic [LEN-1:0] sh;

    // Synchronizer chain plus one history flop for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n)
            sh <= '0;
        else
            sh <= {sh[LEN-2:0], async_in};
    end

    // Rising edge: synchronized level high, previous level low
    always_comb rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/tseq_engine.sv
// Module: tseq_engine
// Steps through the entry table from index 0. Each entry's repeat counter
// advances on every fast cycle or on each slow rising edge, as its select
// bit chooses. The run ends after a stop entry or after the last entry.
// Assumes the table is stable while busy.
module tseq_engine
    import tseq_pkg::*;
#(
    parameter int NUM = 10,
    parameter int DW  = 16,
    parameter int IW  = $clog2(NUM)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     slow_rise,
    input  logic [NUM-1:0][DW-1:0]   tbl,
    output logic                     busy,
    output logic [IW-1:0]            idx,
    output logic [REP_W-1:0]         cnt,
    output logic [DW-1:0]            cur
);
    logic tick;
    logic expire;
    logic last;
    logic unused_spare;

    // Pick the active entry without indexing past the table
    always_comb begin
        cur = '0;
        for (int i = 0; i < NUM; i++)
            if (idx == IW'(i))
                cur = tbl[i];
    end

    // Count enable, expiry and end-of-run decode
    always_comb begin
        tick   = cur[SEL_BIT] ? slow_rise : 1'b1;
        expire = tick && (cnt == cur[REP_LSB +: REP_W]);
        last   = cur[STOP_BIT] || (idx == IW'(NUM - 1));
    end

    assign unused_spare = ^cur[STOP_BIT-1:DAC_BIT+1];

    // Run state, entry index and repeat counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            idx  <= '0;
            cnt  <= '0;
        end else if (!busy) begin
            if (start) begin
                busy <= 1'b1;
                idx  <= '0;
                cnt  <= '0;
            end
        end else if (expire) begin
            cnt <= '0;
            if (last)
                busy <= 1'b0;
            else
                idx <= idx + 1'b1;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/tseq_top.sv
// Module: tseq_top
// Programmable timing state sequencer: entry table, slow-edge synchronizer
// and stepping engine, with outputs gated low while idle. Assumes slow_clk
// is much slower than clk.
module tseq_top
    import tseq_pkg::*;
#(
    parameter int NUM         = 10,
    parameter int AW          = 4,
    parameter int SYNC_STAGES = 2,
    localparam int IW         = $clog2(NUM)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                slow_clk,
    input  logic                start,
    input  logic                wr_en,
    input  logic [AW-1:0]       wr_addr,
    input  logic [ENTRY_W-1:0]  wr_data,
    output logic                busy,
    output logic                exc_en,
    output logic                cap_en,
    output logic                osc_en,
    output logic                dac_en,
    output logic [1:0]          chan
);
    logic [NUM-1:0][ENTRY_W-1:0] tbl;
    logic                        slow_rise;
    logic [IW-1:0]               idx;
    logic [REP_W-1:0]            cnt;
    logic [ENTRY_W-1:0]          cur;
    drive_t                      drv;

    tseq_entry_bank #(.NUM(NUM), .DW(ENTRY_W), .AW(AW)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .lock    (busy),
        .tbl     (tbl)
    );

    tseq_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (slow_clk),
        .rise     (slow_rise)
    );

    tseq_engine #(.NUM(NUM), .DW(ENTRY_W)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .slow_rise (slow_rise),
        .tbl       (tbl),
        .busy      (busy),
        .idx       (idx),
        .cnt       (cnt),
        .cur       (cur)
    );

    // Output group from the active entry, forced low when idle
    always_comb begin
        drv = '0;
        if (busy) begin
            drv.exc  = cur[EXC_BIT];
            drv.cap  = cur[CAP_BIT];
            drv.osc  = cur[OSC_BIT];
            drv.dac  = cur[DAC_BIT];
            drv.chan = cur[CHAN_LSB +: 2];
        end
    end

    assign exc_en = drv.exc;
    assign cap_en = drv.cap;
    assign osc_en = drv.osc;
    assign dac_en = drv.dac;
    assign chan   = drv.chan;
endmodule

// File: rtl/tseq_checker.sv
// Module: tseq_checker
// Temporal properties of the sequencer, bound to tseq_top. Assumes the
// signal names of tseq_top.
module tseq_checker
    import tseq_pkg::*;
#(
    parameter int NUM = 10,
    parameter int IW  = $clog2(NUM)
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        start,
    input logic                        busy,
    input logic [IW-1:0]               idx,
    input logic [REP_W-1:0]            cnt,
    input logic [ENTRY_W-1:0]          cur,
    input logic [NUM-1:0][ENTRY_W-1:0] tbl
);
    // R2
    start_entry0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && idx == '0 && cnt == '0));

    // R3
    step_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && idx != $past(idx)) |-> (idx == $past(idx) + 1'b1));

    // R8
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (idx <= IW'(NUM - 1)));

    // R5
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt <= cur[REP_LSB +: REP_W]));

    // R7
    run_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(cur[STOP_BIT]) || $past(idx) == IW'(NUM - 1)));

    // R9
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && idx != '0) |=> (!busy || idx != '0));

    // R10
    table_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(tbl));
endmodule

bind tseq_top tseq_checker #(.NUM(NUM)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .idx   (idx),
    .cnt   (cnt),
    .cur   (cur),
    .tbl   (tbl)
);

// File: tb/tseq_top_bench.sv
`timescale 1ns/1ps
module tseq_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_clk = 1'b0;
    logic        start = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        busy, exc_en, cap_en, osc_en, dac_en;
    logic [1:0]  chan;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;
    bit done    = 0;

    // Reference state built from the requirements
    logic [15:0] m_tbl [10];
    logic        m_busy;
    int          m_idx;
    int          m_cnt;
    logic        m_s0, m_s1, m_s2;
    int          slow_half = 0;
    int          slow_ph   = 0;

    tseq_top u_tseq_top (
        .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .start(start),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .exc_en(exc_en), .cap_en(cap_en), .osc_en(osc_en),
        .dac_en(dac_en), .chan(chan)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            errors++;
            $display("FAIL watchdog: got %0d cycles expected completion", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    function automatic logic [15:0] mk(int rep, bit sel, int ch, bit e, bit c, bit o, bit d, bit stp);
        return {stp, 3'b000, d, o, c, e, 2'(ch), sel, 5'(rep)};
    endfunction

    function automatic logic [6:0] expected();
        logic [15:0] w;
        if (!m_busy) return 7'b0;
        w = m_tbl[m_idx];
        return {1'b1, w[8], w[9], w[10], w[11], w[7:6]};
    endfunction

    task automatic check(string tag, logic [6:0] act, logic [6:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic check_int(string tag, int act, int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // One clock: advance the reference, compare at the falling edge, move slow_clk
    task automatic step(string tag);
        logic rise;
        logic [15:0] w;
        bit tk;
        @(posedge clk);
        rise = m_s1 & ~m_s2;
        if (!rst_n) begin
            m_busy = 0; m_idx = 0; m_cnt = 0; m_s0 = 0; m_s1 = 0; m_s2 = 0;
            for (int i = 0; i < 10; i++) m_tbl[i] = '0;
        end else begin
            if (wr_en && !m_busy && wr_addr < 10) m_tbl[wr_addr] = wr_data;
            m_s2 = m_s1; m_s1 = m_s0; m_s0 = slow_clk;
            if (!m_busy) begin
                if (start) begin m_busy = 1; m_idx = 0; m_cnt = 0; end
            end else begin
                w  = m_tbl[m_idx];
                tk = w[5] ? rise : 1'b1;
                if (tk) begin
                    if (m_cnt == int'(w[4:0])) begin
                        m_cnt = 0;
                        if (w[15] || m_idx == 9) m_busy = 0;
                        else m_idx++;
                    end else m_cnt++;
                end
            end
        end
        @(negedge clk);
        check(tag, {busy, exc_en, cap_en, osc_en, dac_en, chan}, expected());
        if (slow_half > 0) begin
            slow_ph++;
            if (slow_ph >= slow_half) begin slow_ph = 0; slow_clk = ~slow_clk; end
        end
    endtask

    task automatic write(int a, logic [15:0] d, string tag);
        wr_en = 1; wr_addr = 4'(a); wr_data = d;
        step(tag);
        wr_en = 0;
    endtask

    task automatic run(string tag, output int busy_cycles);
        busy_cycles = 0;
        start = 1; step(tag); start = 0;
        if (busy) busy_cycles++;
        while (busy && busy_cycles < 2000) begin
            step(tag);
            if (busy) busy_cycles++;
        end
        for (int i = 0; i < 3; i++) step(tag);
    endtask

    task automatic load_fast();
        write(0, mk(0, 0, 1, 1, 0, 0, 0, 0), "R4 load");
        write(1, mk(3, 0, 2, 0, 1, 0, 0, 0), "R4 load");
        write(2, mk(1, 0, 3, 0, 0, 1, 1, 0), "R4 load");
        write(3, mk(5, 0, 0, 1, 1, 1, 1, 1), "R4 load");
    endtask

    task automatic t_reset();
        for (int i = 0; i < 3; i++) step("R1 reset");
        @(negedge clk); rst_n = 1;
        step("R1 idle after reset");
        // R11: entry contents loaded while idle must not reach the outputs
        write(0, 16'hFFC0, "R11 idle outputs low");
        step("R11 idle outputs low");
    endtask

    task automatic t_fast();
        int n;
        load_fast();
        run("R2 R3 R4 R5 R7 fast run", n);
        check_int("R5 fast run length", n, 1 + 4 + 2 + 6);
    endtask

    task automatic t_slow_mix();
        int n;
        slow_half = 3; slow_ph = 0;
        write(0, mk(2, 0, 0, 1, 0, 0, 0, 0), "R6 load");
        write(1, mk(1, 1, 1, 0, 1, 0, 0, 0), "R6 load");
        write(2, mk(3, 0, 2, 0, 0, 1, 0, 0), "R6 load");
        write(3, mk(0, 1, 3, 0, 0, 0, 1, 0), "R6 load");
        write(4, mk(0, 0, 1, 1, 1, 0, 0, 1), "R6 load");
        run("R6 mixed clocks", n);
        for (int i = 0; i < 4; i++) step("R6 shifted phase");
        run("R6 mixed clocks shifted", n);
        slow_half = 0;
    endtask

    task automatic t_entry9();
        int n;
        for (int i = 0; i < 10; i++)
            write(i, mk(1, 0, i % 4, i[0], i[1], i[2], i[3], 0), "R8 load");
        run("R8 last entry ends run", n);
        check_int("R8 run length", n, 20);
    endtask

    task automatic t_start_busy();
        int n;
        load_fast();
        start = 1; step("R9 start"); start = 0; n = 1;
        for (int i = 0; i < 4; i++) begin step("R9 run"); n++; end
        start = 1; step("R9 start while busy"); start = 0; n++;
        while (busy && n < 2000) begin step("R9 run"); if (busy) n++; end
        for (int i = 0; i < 2; i++) step("R9 after");
        check_int("R9 run length unchanged", n, 13);
    endtask

    task automatic t_write_busy();
        int n;
        load_fast();
        start = 1; step("R10 start"); start = 0;
        step("R10 run");
        write(1, mk(9, 0, 0, 0, 0, 0, 0, 1), "R10 write while busy");
        while (busy) step("R10 run");
        write(12, mk(0, 0, 3, 1, 1, 1, 1, 1), "R10 write to address 12");
        run("R10 rerun old table", n);
        check_int("R10 busy write blocked", n, 13);
        write(1, mk(0, 0, 3, 1, 1, 1, 1, 1), "R10 idle write");
        run("R10 rerun new table", n);
        check_int("R10 idle write applied", n, 2);
    endtask

    initial begin
        t_reset();
        t_fast();
        t_slow_mix();
        t_entry9();
        t_start_busy();
        t_write_busy();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule